// File: doc/BRIEF.md
# Piecewise-Linear Sigmoid Approximator

This block stands in for the logistic sigmoid in a fixed-point neural datapath. It takes a signed two's-complement pre-activation value and returns an unsigned activation in the range 0 to 1. The curve is built from four straight segments. The block picks a segment by comparing the absolute value of the input with three fixed breakpoints: 1, 2.375 and 5. It then adds that segment's slope term and intercept. Every slope is a power of two, so each slope term is a right shift and the datapath needs no multiplier. A negative input gives the complement, one minus the value computed for its magnitude.

The input carries `FRAC_W` fractional bits in an `IN_W`-bit word. The output carries the same `FRAC_W` fractional bits plus one integer bit, so that exactly 1.0 can be represented. The interface is a simple valid-qualified stream with no backpressure. A new sample may be presented on every cycle, and each result leaves a fixed two register stages later.

Top module: `sig_pwl_approx`

## Requirements
In the requirements, m is the input magnitude in LSB units, with `FRAC_W`=8: 1.0 is code 256, 2.375 is 608 and 5.0 is 1280. Divisions truncate toward zero.
- R1: For m < 256 and a non-negative input, the output is m/4 + 128 (0.25·|x| + 0.5).
- R2: For 256 ≤ m < 608 and a non-negative input, the output is m/8 + 160 (0.125·|x| + 0.625).
- R3: For 608 ≤ m < 1280 and a non-negative input, the output is m/32 + 216 (0.03125·|x| + 0.84375).
- R4: For m ≥ 1280 and a non-negative input, the output is exactly 256 (1.0).
- R5: For a negative input, the output is 256 minus the value that R1 to R4 give for m.
- R6: The most negative input code, 0x8000, is treated as a magnitude of 32768. It falls in the saturated segment, so its output is 0.
- R7: An input presented with `valid_i` high before rising edge k appears on `y_o`, with `valid_o` high, after edge k+1. `valid_o` is high for exactly one cycle per accepted input, and back-to-back inputs produce back-to-back results.
- R8: A cycle without `valid_i` produces no result two edges later: `valid_o` stays low and `y_o` keeps its previous value.
- R9: While `rst_ni` is low, `valid_o` and `y_o` are 0.
- R10: Every result lies between 0 and 256 inclusive, and no intermediate sum carries into bits above the output width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `x_i` in this cycle |
| x_i | input | IN_W | Signed pre-activation, FRAC_W fractional bits |
| valid_o | output | 1 | `y_o` holds a new result |
| y_o | output | FRAC_W+1 | Unsigned activation, FRAC_W fractional bits |

## Verification
The input stage can accept a new sample on the same edge that the output stage registers the result of the sample before it. On a clean stream both events occur on every edge. The bench provokes this by sweeping every 16-bit input code at one sample per cycle, with a regular gap in `valid_i`. At every falling edge it compares `valid_o` and `y_o` with the value expected for the sample presented two edges earlier, or checks that the output held its value after a gap. A directed pass then feeds the codes on both sides of each breakpoint, plus 0x8000, back to back.

// File: rtl/sig_pwl_pkg.sv
package sig_pwl_pkg;
  // Segment order follows increasing magnitude.
  typedef enum logic [1:0] {
    SEG_CENTER = 2'd0,
    SEG_KNEE   = 2'd1,
    SEG_TAIL   = 2'd2,
    SEG_SAT    = 2'd3
  } seg_e;
endpackage

// File: rtl/pwl_mag_region.sv
module pwl_mag_region
  import sig_pwl_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 8
) (
  input  logic [IN_W-1:0] x_i,
  output logic [IN_W-1:0] mag_o,
  output logic            neg_o,
  output seg_e            seg_o
);
  localparam logic [IN_W-1:0] BP_ONE  = IN_W'(1 << FRAC_W);
  localparam logic [IN_W-1:0] BP_KNEE = IN_W'(19 << (FRAC_W - 3));
  localparam logic [IN_W-1:0] BP_SAT  = IN_W'(5 << FRAC_W);

  always_comb begin
    neg_o = x_i[IN_W-1];
    // unsigned view: the most negative code maps to 2^(IN_W-1) without wrap
    mag_o = neg_o ? (~x_i + 1'b1) : x_i;
    if (mag_o < BP_ONE)       seg_o = SEG_CENTER;
    else if (mag_o < BP_KNEE) seg_o = SEG_KNEE;
    else if (mag_o < BP_SAT)  seg_o = SEG_TAIL;
    else                      seg_o = SEG_SAT;
  end
endmodule

// File: rtl/pwl_segment_eval.sv
module pwl_segment_eval
  import sig_pwl_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = FRAC_W + 1
) (
  input  logic [IN_W-1:0]  mag_i,
  input  seg_e             seg_i,
  output logic [OUT_W-1:0] y_mag_o
);
  localparam logic [IN_W-1:0] C_CENTER = IN_W'(1 << (FRAC_W - 1));
  localparam logic [IN_W-1:0] C_KNEE   = IN_W'(5 << (FRAC_W - 3));
  localparam logic [IN_W-1:0] C_TAIL   = IN_W'(27 << (FRAC_W - 5));
  localparam logic [IN_W-1:0] C_ONE    = IN_W'(1 << FRAC_W);

  logic [IN_W-1:0] sum;

  always_comb begin
    unique case (seg_i)
      SEG_CENTER: sum = (mag_i >> 2) + C_CENTER;
      SEG_KNEE:   sum = (mag_i >> 3) + C_KNEE;
      SEG_TAIL:   sum = (mag_i >> 5) + C_TAIL;
      default:    sum = C_ONE;
    endcase
    y_mag_o = sum[OUT_W-1:0];
  end

  always_comb begin
    AST_NO_OVERFLOW: assert (sum[IN_W-1:OUT_W] == '0 && sum[OUT_W-1:0] <= C_ONE[OUT_W-1:0]); // R10
  end
endmodule

// File: rtl/pwl_mirror.sv
module pwl_mirror #(
  parameter int FRAC_W = 8,
  parameter int OUT_W  = FRAC_W + 1
) (
  input  logic [OUT_W-1:0] y_mag_i,
  input  logic             neg_i,
  output logic [OUT_W-1:0] y_o
);
  localparam logic [OUT_W-1:0] ONE = OUT_W'(1 << FRAC_W);

  always_comb y_o = neg_i ? (ONE - y_mag_i) : y_mag_i;
endmodule

// File: rtl/sig_pwl_approx.sv
module sig_pwl_approx
  import sig_pwl_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IN_W-1:0]   x_i,
  output logic              valid_o,
  output logic [FRAC_W:0]   y_o
);
  localparam int OUT_W = FRAC_W + 1;
  localparam logic [OUT_W-1:0] ONE = OUT_W'(1 << FRAC_W);

  logic [IN_W-1:0]  mag_d;
  logic             neg_d;
  seg_e             seg_d;

  logic             s1_valid_q;
  logic [IN_W-1:0]  s1_mag_q;
  logic             s1_neg_q;
  seg_e             s1_seg_q;

  logic [OUT_W-1:0] y_mag_d;
  logic [OUT_W-1:0] y_d;

  pwl_mag_region #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_region (
    .x_i   (x_i),
    .mag_o (mag_d),
    .neg_o (neg_d),
    .seg_o (seg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_mag_q   <= '0;
      s1_neg_q   <= 1'b0;
      s1_seg_q   <= SEG_CENTER;
    end else begin
      s1_valid_q <= valid_i;
      if (valid_i) begin
        s1_mag_q <= mag_d;
        s1_neg_q <= neg_d;
        s1_seg_q <= seg_d;
      end
    end
  end

  pwl_segment_eval #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_eval (
    .mag_i   (s1_mag_q),
    .seg_i   (s1_seg_q),
    .y_mag_o (y_mag_d)
  );

  pwl_mirror #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_mirror (
    .y_mag_i (y_mag_d),
    .neg_i   (s1_neg_q),
    .y_o     (y_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= s1_valid_q;
      if (s1_valid_q) y_o <= y_d;
    end
  end

  AST_STAGE_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_valid_q); // R7
  AST_STAGE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q |=> valid_o); // R7
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_q |=> (!valid_o && $stable(y_o))); // R8
  AST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (y_o <= ONE)); // R10
  AST_SAT_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_seg_q == SEG_SAT) |=> (y_o == ($past(s1_neg_q) ? '0 : ONE))); // R4
endmodule

// File: tb/sig_pwl_approx_tb_top.sv
module sig_pwl_approx_tb_top;
  localparam int IN_W = 16;
  localparam int FRAC_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [IN_W-1:0] x_i = '0;
  logic valid_o;
  logic [FRAC_W:0] y_o;

  int checks = 0;
  int errors = 0;
  logic a_v = 1'b0, b_v = 1'b0;
  logic [IN_W-1:0] a_x = '0, b_x = '0;
  int last_y = 0;

  always #5 clk = ~clk;

  sig_pwl_approx #(.IN_W(IN_W), .FRAC_W(FRAC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .valid_o(valid_o), .y_o(y_o)
  );

  function automatic int expect_of(input logic [IN_W-1:0] code);
    int x, m, y;
    x = int'($signed(code));
    m = (x < 0) ? -x : x;
    if (m < 256)       y = m / 4 + 128;
    else if (m < 608)  y = m / 8 + 160;
    else if (m < 1280) y = m / 32 + 216;
    else               y = 256;
    if (x < 0) y = 256 - y;
    return y;
  endfunction

  function automatic string tag_of(input logic [IN_W-1:0] code);
    int x, m;
    x = int'($signed(code));
    m = (x < 0) ? -x : x;
    if (code == 16'h8000) return "R6";
    if (x < 0)            return "R5";
    if (m < 256)          return "R1";
    if (m < 608)          return "R2";
    if (m < 1280)         return "R3";
    return "R4";
  endfunction

  task automatic check_slot(input logic v, input logic [IN_W-1:0] code);
    int e;
    checks++;
    if (valid_o !== v) begin
      errors++;
      $display("FAIL R7 valid_o act=%0b exp=%0b code=%h", valid_o, v, code);
    end
    checks++;
    if (v) begin
      e = expect_of(code);
      if (int'(y_o) != e) begin
        errors++;
        $display("FAIL %s code=%h act=%0d exp=%0d", tag_of(code), code, y_o, e);
      end
      if (y_o > 9'd256) begin
        errors++;
        $display("FAIL R10 range act=%0d exp<=256", y_o);
      end
      last_y = e;
    end else if (int'(y_o) != last_y) begin
      errors++;
      $display("FAIL R8 hold act=%0d exp=%0d", y_o, last_y);
    end
  endtask

  task automatic step(input logic v, input logic [IN_W-1:0] code);
    @(negedge clk);
    check_slot(b_v, b_x);
    b_v = a_v; b_x = a_x;
    a_v = v;   a_x = code;
    valid_i = v; x_i = code;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || y_o !== '0) begin
      errors++;
      $display("FAIL R9 reset act=%0b/%0d exp=0/0", valid_o, y_o);
    end
    rst_ni = 1'b1;
    // full code sweep, one sample per cycle with a periodic gap
    for (int i = 0; i < 65536; i++) step((i % 7) != 5, IN_W'(i));
    // boundary codes back to back: R1 R2 R3 R4 R5 R6
    step(1'b1, 16'h0000); step(1'b1, 16'h00FF); step(1'b1, 16'h0100);
    step(1'b1, 16'h025F); step(1'b1, 16'h0260); step(1'b1, 16'h04FF);
    step(1'b1, 16'h0500); step(1'b1, 16'h7FFF); step(1'b1, 16'h8000);
    step(1'b1, 16'hFF01); step(1'b1, 16'hFF00); step(1'b1, 16'hFDA0);
    step(1'b1, 16'hFB00); step(1'b1, 16'h8001);
    step(1'b0, 16'h1234); step(1'b0, 16'h0000); step(1'b0, 16'h0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule